// File: doc/BRIEF.md
# External Interrupt Sense Detector

This block watches a single asynchronous interrupt pin and turns its activity into an interrupt request for a processor core. A 2-bit sense-select input picks one of four detection styles: the pin being low, any transition of the pin, a high-to-low transition, or a low-to-high transition. The pin first passes through a synchroniser. A history register then holds the previous synchronised sample, and each transition is found by comparing the current sample with that history.

In the three transition modes a detected edge sets a sticky request flag. The flag stays set until the core sends a one-cycle acknowledge. In low-level mode nothing is stored: the request simply mirrors the synchronised pin, so the pin must still be low when the core looks at it. The request reaches the core's interrupt line only when both the per-source mask and the global interrupt enable are set. The flag keeps recording edges while either of them is clear, so a pending edge is delivered as soon as both are enabled. When the sense select changes, the flag is cleared and any edge seen in that same cycle is discarded.

Top module: `extint_sense_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released with the pin held high, `reqFlag` and `intReq` are 0. The synchroniser and history registers reset to the idle-high level.
- R2: With `senseSel` = 2'b00 (low level), `reqFlag` is 1 exactly when the pin value sampled two rising clock edges earlier is 0. It falls back to 0 two edges after the pin returns high, and `intAck` has no effect on it.
- R3: With `senseSel` = 2'b11 (rising), a low-to-high pin change applied before clock edge j makes `reqFlag` 1 after edge j+2. A high-to-low change sets nothing.
- R4: With `senseSel` = 2'b10 (falling), a high-to-low pin change before edge j makes `reqFlag` 1 after edge j+2. A low-to-high change sets nothing.
- R5: With `senseSel` = 2'b01 (any change), both a rising and a falling pin change set `reqFlag` after edge j+2.
- R6: In the transition modes, a pin pulse that lasts exactly one clock period is still detected and sets `reqFlag`.
- R7: In the transition modes the flag is sticky. It holds through later pin activity until an edge samples `intAck` = 1, which clears it. If a new qualifying edge is detected at that same clock edge, the flag stays set.
- R8: A change of `senseSel` clears the flag at the next clock edge. The change itself creates no request, even when the pin level differs from what the new mode would call an edge.
- R9: `intReq` is 1 only when `reqFlag`, `srcMask` and `globalIntEn` are all 1. A flag set while masked appears on `intReq` in the same cycle that both enables become 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 1 | Raw external interrupt pin |
| senseSel | input | 2 | Detection style: 00 low level, 01 any change, 10 falling, 11 rising |
| srcMask | input | 1 | Per-source interrupt mask, 1 enables |
| globalIntEn | input | 1 | Global interrupt enable |
| intAck | input | 1 | One-cycle acknowledge from the core, clears the edge flag |
| reqFlag | output | 1 | Request flag: the sticky edge flag, or the live level in low-level mode |
| intReq | output | 1 | Gated interrupt line toward the core |

## Verification
The hardest case to reach from the ports is an acknowledge that arrives in the same clock edge as a newly detected edge. That edge is only visible two edges after the pin moves. The stimulus first leaves the flag set, then drops the pin. It counts two rising edges and raises `intAck` for exactly the third, so the clear and the set collide. A follow-up lone acknowledge then proves that the clear path itself works. Mode-change suppression is reached by parking the pin low in level mode and switching to falling-edge mode, where a naive design would report a false edge.

// File: rtl/extint_pkg.sv
package extint_pkg;

  localparam int SENSE_W = 2;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } senseMode_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic flagSet;    // qualified edge: set the sticky flag
    logic flagClear;  // acknowledge or mode change: clear it
    logic levelSel;   // low-level mode: request follows the pin
  } ctrlStrobe_t;

endpackage

// File: rtl/extint_edge_path.sv
module extint_edge_path
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit IDLE_LEVEL  = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pinRaw,
  input  ctrlStrobe_t strobe,
  output logic        riseSeen,
  output logic        fallSeen,
  output logic        reqFlag
);

  localparam int TOP_IDX = SYNC_STAGES - 1;

  logic [TOP_IDX:0] syncQ;
  logic             pinSync;
  logic             prevQ;
  logic             flagQ;

  // metastability chain, pin enters at bit 0
  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= IDLE_LEVEL;
        else       syncQ <= pinRaw;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= {SYNC_STAGES{IDLE_LEVEL}};
        else       syncQ <= {syncQ[TOP_IDX-1:0], pinRaw};
      end
    end
  endgenerate

  assign pinSync = syncQ[TOP_IDX];

  // history stage, always re-primed from the current sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= IDLE_LEVEL;
    else       prevQ <= pinSync;
  end

  assign riseSeen = pinSync & ~prevQ;
  assign fallSeen = ~pinSync & prevQ;

  // sticky flag, a set beats a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 flagQ <= 1'b0;
    else if (strobe.flagSet)   flagQ <= 1'b1;
    else if (strobe.flagClear) flagQ <= 1'b0;
  end

  assign reqFlag = strobe.levelSel ? ~pinSync : flagQ;

endmodule

// File: rtl/extint_sense_ctrl.sv
module extint_sense_ctrl
  import extint_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [SENSE_W-1:0] senseSel,
  input  logic               ackIn,
  input  logic               riseSeen,
  input  logic               fallSeen,
  output ctrlStrobe_t        strobe
);

  senseMode_e modeNow;
  senseMode_e modeQ;
  logic       modeChange;
  logic       edgeHit;

  assign modeNow = senseMode_e'(senseSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= SENSE_LOW;
    else       modeQ <= modeNow;
  end

  assign modeChange = (modeNow != modeQ);

  always_comb begin
    unique case (modeNow)
      SENSE_ANY:  edgeHit = riseSeen | fallSeen;
      SENSE_FALL: edgeHit = fallSeen;
      SENSE_RISE: edgeHit = riseSeen;
      default:    edgeHit = 1'b0;
    endcase
  end

  // an edge seen during a mode switch is dropped
  always_comb begin
    strobe.flagSet   = edgeHit & ~modeChange;
    strobe.flagClear = modeChange | ackIn;
    strobe.levelSel  = (modeNow == SENSE_LOW);
  end

endmodule

// File: rtl/extint_sense_top.sv
module extint_sense_top
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit IDLE_LEVEL  = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinIn,
  input  logic [1:0] senseSel,
  input  logic       srcMask,
  input  logic       globalIntEn,
  input  logic       intAck,
  output logic       reqFlag,
  output logic       intReq
);

  ctrlStrobe_t strobe;
  logic        riseSeen;
  logic        fallSeen;

  extint_sense_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .senseSel (senseSel),
    .ackIn    (intAck),
    .riseSeen (riseSeen),
    .fallSeen (fallSeen),
    .strobe   (strobe)
  );

  extint_edge_path #(
    .SYNC_STAGES (SYNC_STAGES),
    .IDLE_LEVEL  (IDLE_LEVEL)
  ) i_path (
    .clk      (clk),
    .rstN     (rstN),
    .pinRaw   (pinIn),
    .strobe   (strobe),
    .riseSeen (riseSeen),
    .fallSeen (fallSeen),
    .reqFlag  (reqFlag)
  );

  assign intReq = reqFlag & srcMask & globalIntEn;

endmodule

// File: rtl/extint_sense_chk.sv
module extint_sense_chk (
  input logic       clk,
  input logic       rstN,
  input logic       pinIn,
  input logic [1:0] senseSel,
  input logic       srcMask,
  input logic       globalIntEn,
  input logic       intAck,
  input logic       reqFlag,
  input logic       intReq
);

  // edges since reset release, saturating; keeps every $past inside the reset window
  logic [2:0] warm;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              warm <= 3'd0;
    else if (warm != 3'd7)  warm <= warm + 3'd1;
  end

  p_level_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 3'd2 && senseSel == 2'b00) |-> (reqFlag == !$past(pinIn, 2)));

  p_rise_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 3'd5 && $past(pinIn, 4) == 1'b0 && $past(pinIn, 3) == 1'b1 &&
     $past(senseSel, 2) == 2'b11 && $past(senseSel, 1) == 2'b11 &&
     senseSel == 2'b11) |-> reqFlag);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 3'd1 && senseSel != 2'b00 && senseSel == $past(senseSel) &&
     reqFlag && !intAck) |=> (reqFlag || senseSel == 2'b00));

  p_mode_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 3'd1 && senseSel != $past(senseSel)) |=>
    (!reqFlag || senseSel == 2'b00));

  p_gate_enable_r9: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (srcMask && globalIntEn && reqFlag));

endmodule

bind extint_sense_top extint_sense_chk i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .pinIn       (pinIn),
  .senseSel    (senseSel),
  .srcMask     (srcMask),
  .globalIntEn (globalIntEn),
  .intAck      (intAck),
  .reqFlag     (reqFlag),
  .intReq      (intReq)
);

// File: tb/test_extint_sense_top.sv
module test_extint_sense_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 20000;

  logic       clk = 1'b0;
  logic       rstN;
  logic       pinIn;
  logic [1:0] senseSel;
  logic       srcMask;
  logic       globalIntEn;
  logic       intAck;
  logic       reqFlag;
  logic       intReq;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  extint_sense_top i_extint_sense_top (
    .clk         (clk),
    .rstN        (rstN),
    .pinIn       (pinIn),
    .senseSel    (senseSel),
    .srcMask     (srcMask),
    .globalIntEn (globalIntEn),
    .intAck      (intAck),
    .reqFlag     (reqFlag),
    .intReq      (intReq)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // wait n rising edges, then settle at the falling edge
  task automatic waitSample(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulseAck;
    intAck = 1'b1;
    @(negedge clk);
    intAck = 1'b0;
  endtask

  task automatic setSense(input logic [1:0] v);
    senseSel = v;
    waitSample(2);
  endtask

  task automatic applyReset;
    @(negedge clk);
    rstN = 1'b0; pinIn = 1'b1; senseSel = 2'b00;
    srcMask = 1'b1; globalIntEn = 1'b1; intAck = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reqFlag in reset", reqFlag, 1'b0);
    chk("R1 intReq in reset", intReq, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reqFlag after release", reqFlag, 1'b0);
  endtask

  task automatic testLevel;
    applyReset();
    pinIn = 1'b0;
    waitSample(1);
    chk("R2 latency one edge", reqFlag, 1'b0);
    waitSample(1);
    chk("R2 low level seen", reqFlag, 1'b1);
    chk("R9 level passes enables", intReq, 1'b1);
    pulseAck();
    chk("R2 ack ignored in level mode", reqFlag, 1'b1);
    pinIn = 1'b1;
    waitSample(2);
    chk("R2 not latched", reqFlag, 1'b0);
  endtask

  task automatic testRise;
    applyReset();
    setSense(2'b11);
    pinIn = 1'b0;
    waitSample(3);
    chk("R3 falling ignored", reqFlag, 1'b0);
    pinIn = 1'b1;
    waitSample(2);
    chk("R3 not before edge j+2", reqFlag, 1'b0);
    waitSample(1);
    chk("R3 rising sets flag", reqFlag, 1'b1);
    pinIn = 1'b0;
    waitSample(3);
    chk("R7 flag sticky", reqFlag, 1'b1);
    pulseAck();
    chk("R7 ack clears flag", reqFlag, 1'b0);
  endtask

  task automatic testFall;
    applyReset();
    pinIn = 1'b0;
    waitSample(2);
    setSense(2'b10);
    pinIn = 1'b1;
    waitSample(3);
    chk("R4 rising ignored", reqFlag, 1'b0);
    pinIn = 1'b0;
    waitSample(3);
    chk("R4 falling sets flag", reqFlag, 1'b1);
    pulseAck();
    chk("R4 ack clears", reqFlag, 1'b0);
  endtask

  task automatic testAny;
    applyReset();
    setSense(2'b01);
    pinIn = 1'b0;
    waitSample(3);
    chk("R5 fall sets flag", reqFlag, 1'b1);
    pulseAck();
    chk("R5 ack clears", reqFlag, 1'b0);
    pinIn = 1'b1;
    waitSample(3);
    chk("R5 rise sets flag", reqFlag, 1'b1);
    pulseAck();
  endtask

  task automatic testPulse;
    applyReset();
    setSense(2'b10);
    pinIn = 1'b0;
    @(negedge clk);
    pinIn = 1'b1;
    waitSample(2);
    chk("R6 one-cycle low pulse caught", reqFlag, 1'b1);
    pulseAck();
    setSense(2'b11);
    pinIn = 1'b0;
    waitSample(3);
    pulseAck();
    pinIn = 1'b1;
    @(negedge clk);
    pinIn = 1'b0;
    waitSample(2);
    chk("R6 one-cycle high pulse caught", reqFlag, 1'b1);
  endtask

  task automatic testAckRace;
    applyReset();
    setSense(2'b10);
    pinIn = 1'b0;
    waitSample(3);
    chk("R7 flag set before race", reqFlag, 1'b1);
    pinIn = 1'b1;
    waitSample(3);
    pinIn = 1'b0;
    waitSample(2);
    pulseAck();
    chk("R7 edge wins over ack", reqFlag, 1'b1);
    pulseAck();
    chk("R7 lone ack clears", reqFlag, 1'b0);
  endtask

  task automatic testMask;
    applyReset();
    srcMask = 1'b0;
    setSense(2'b11);
    pinIn = 1'b0;
    waitSample(3);
    pinIn = 1'b1;
    waitSample(3);
    chk("R9 flag recorded while masked", reqFlag, 1'b1);
    chk("R9 masked no intReq", intReq, 1'b0);
    srcMask = 1'b1; globalIntEn = 1'b0;
    #1;
    chk("R9 global off no intReq", intReq, 1'b0);
    globalIntEn = 1'b1;
    #1;
    chk("R9 pending delivered on enable", intReq, 1'b1);
  endtask

  task automatic testSenseChange;
    applyReset();
    setSense(2'b11);
    pinIn = 1'b0;
    waitSample(3);
    pinIn = 1'b1;
    waitSample(3);
    chk("R8 flag set before switch", reqFlag, 1'b1);
    senseSel = 2'b10;
    waitSample(1);
    chk("R8 switch clears flag", reqFlag, 1'b0);
    senseSel = 2'b00;
    pinIn = 1'b0;
    waitSample(3);
    chk("R8 level mode low", reqFlag, 1'b1);
    senseSel = 2'b10;
    waitSample(3);
    chk("R8 no spurious fall after switch", reqFlag, 1'b0);
  endtask

  initial begin
    testLevel();
    testRise();
    testFall();
    testAny();
    testPulse();
    testAckRace();
    testMask();
    testSenseChange();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule